// File: doc/BRIEF.md
# Muxed-Bus Control Register and Interrupt Block

This block is the control and status register interface of a line-side physical-layer device. A host reaches it over an 8-bit bus that carries both address and data on the same wires. The bus has four asynchronous strobes: an address-latch enable, plus active-low chip select, read and write. Each strobe, and the bus itself, passes through a synchronizer into the system clock. A bus-cycle state machine then turns the strobe levels into single-cycle read-start and write-commit events.

The block holds three registers. The control register carries a transmit-parity-check enable and a 2-bit line-rate multiplier select; the multiplier select is also decoded into a one-hot rate indication. The interrupt mask register enables each event source. The interrupt status register is sticky, is set by internal single-cycle event strobes, and clears when it is read. An active-low interrupt request is pulled low whenever a status bit is set and its mask bit is enabled. The pad is open-drain, so only the low level is actively driven.

The bus state machine has three states. ST_IDLE goes to ST_READ when chip select and read are both asserted and write is not; this transition raises the read-start event. ST_IDLE goes to ST_WRITE when chip select and write are both asserted and read is not. ST_READ returns to ST_IDLE as soon as read or chip select is released. ST_WRITE returns to ST_IDLE as soon as write or chip select is released, and this transition raises the write-commit event.

Top module: `mbc_top`

## Requirements
- R1: After the asynchronous active-low reset, the block is in this state: irq_n_o is 1, par_chk_en_o is 0, mult_sel_o is 00, line_rate_o is 001, and the control, mask and status registers all read 0.
- R2: The address on ad_i is captured when the synchronized ale_i falls, two clock stages after the pin. Values placed on ad_i while ale_i is low do not change the captured address, and the address stays in force for later accesses until the next falling edge of ale_i.
- R3: A write captures the bus value present at the trailing edge of wr_n_i or of cs_n_i, whichever rises first. Control and mask hold their values at all other times. The control register layout is bit 0 = parity-check enable and bits 2:1 = multiplier select.
- R4: ad_oe_o is 1 exactly while both rd_n_i and cs_n_i are low. During a read, ad_o carries the addressed register. The register addresses are 0x00 for control, 0x01 for mask and 0x02 for status.
- R5: cs_n_i may stay low across any number of consecutive accesses; each access is framed by rd_n_i or wr_n_i alone.
- R6: line_rate_o is one-hot and decodes the multiplier select: 00 gives 001 (1x), 01 gives 010 (2x), 10 gives 100 (4x), and the reserved value 11 gives 001 (1x).
- R7: Each pulse on evt_i[k] sets status bit k, and the bit stays set until status is read. Event 0 is the transmit parity error and sets its bit only while the parity-check enable is 1.
- R8: irq_n_o is 0 exactly while some status bit and its mask bit are both 1. A masked-off event is still recorded in status.
- R9: A read of status returns the bits that were set before the read started, then clears them. An event arriving in the clock cycle the read starts is kept for the next read.
- R10: Addresses other than 0x00 to 0x02 read as 0, and writes to them have no effect. Writes to the status address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale_i | input | 1 | Address latch enable, asynchronous, address taken on its falling edge |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| rd_n_i | input | 1 | Read strobe, active low, asynchronous |
| wr_n_i | input | 1 | Write strobe, active low, asynchronous |
| ad_i | input | 8 | Multiplexed address/data from the pad |
| ad_o | output | 8 | Read data toward the pad |
| ad_oe_o | output | 1 | Pad output enable for ad_o |
| evt_i | input | NEV | Single-cycle internal event strobes, bit 0 = transmit parity error |
| irq_n_o | output | 1 | Interrupt request, active low, open-drain at the pad |
| par_chk_en_o | output | 1 | Transmit parity check enable |
| mult_sel_o | output | 2 | Raw clock multiplier select field |
| line_rate_o | output | 3 | One-hot decoded multiplier: bit0 1x, bit1 2x, bit2 4x |

## Verification
A status bit that is dropped or that fails to clear shows up on irq_n_o on the clock edge after the event, or after the read, when its mask bit is set. The reference model compares irq_n_o on every cycle, so such an error is caught within one clock. A wrong captured address, or a write committed at the wrong edge, shows up as a wrong value on ad_o at the next read-back. It shows up at once on par_chk_en_o and line_rate_o when the control register is involved. A read snapshot taken at the wrong cycle either loses or duplicates the event that is aimed at the read-start cycle, and that difference is visible in the two status reads that follow.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
    localparam int BUS_W = 8;

    localparam logic [BUS_W-1:0] A_CTRL = 8'h00;
    localparam logic [BUS_W-1:0] A_MASK = 8'h01;
    localparam logic [BUS_W-1:0] A_STAT = 8'h02;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } bus_st_e;

    typedef struct packed {
        logic [1:0] mult;
        logic       par_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/mbc_sync.sv
module mbc_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stg
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/mbc_bus_fsm.sv
module mbc_bus_fsm
    import mbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ale_s,
    input  logic cs_s,
    input  logic rd_s,
    input  logic wr_s,
    output logic ale_fall,
    output logic rd_start,
    output logic rd_active,
    output logic wr_commit
);
    bus_st_e state_q, state_d;
    logic    ale_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ale_d   <= 1'b0;
        end else begin
            state_q <= state_d;
            ale_d   <= ale_s;
        end
    end

    assign ale_fall = ale_d & ~ale_s;

    always_comb begin
        state_d   = state_q;
        rd_start  = 1'b0;
        rd_active = 1'b0;
        wr_commit = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cs_s && rd_s && !wr_s) begin
                    state_d  = ST_READ;
                    rd_start = 1'b1;
                end else if (cs_s && wr_s && !rd_s) begin
                    state_d = ST_WRITE;
                end
            end
            ST_READ: begin
                rd_active = 1'b1;
                if (!(cs_s && rd_s)) state_d = ST_IDLE;
            end
            ST_WRITE: begin
                if (!(cs_s && wr_s)) begin
                    state_d   = ST_IDLE;
                    wr_commit = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/mbc_regs.sv
module mbc_regs
    import mbc_pkg::*;
#(
    parameter int NEV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ale_fall,
    input  logic [BUS_W-1:0] ad_s,
    input  logic             rd_start,
    input  logic             rd_active,
    input  logic             wr_commit,
    input  logic [NEV-1:0]   evt,
    output ctrl_t            ctrl_q,
    output logic [BUS_W-1:0] addr_q,
    output logic [NEV-1:0]   stat_q,
    output logic [NEV-1:0]   ev_set,
    output logic [BUS_W-1:0] rd_data,
    output logic             irq
);
    logic [NEV-1:0]   mask_q;
    logic [NEV-1:0]   stat_clr;
    logic [BUS_W-1:0] rd_live;
    logic [BUS_W-1:0] rd_hold;

    // Event 0 is the parity error source, gated by the check enable.
    assign ev_set   = evt & {{(NEV-1){1'b1}}, ctrl_q.par_en};
    assign stat_clr = (rd_start && addr_q == A_STAT) ? stat_q : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (ale_fall) begin
            addr_q <= ad_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '0;
        end else if (wr_commit) begin
            case (addr_q)
                A_CTRL:  ctrl_q <= ctrl_t'(ad_s[CTRL_W-1:0]);
                A_MASK:  mask_q <= ad_s[NEV-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~stat_clr) | ev_set;
    end

    always_comb begin
        rd_live = '0;
        case (addr_q)
            A_CTRL:  rd_live[CTRL_W-1:0] = ctrl_q;
            A_MASK:  rd_live[NEV-1:0]    = mask_q;
            A_STAT:  rd_live[NEV-1:0]    = stat_q;
            default: rd_live = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rd_hold <= '0;
        else if (rd_start) rd_hold <= rd_live;
    end

    assign rd_data = rd_active ? rd_hold : rd_live;
    assign irq     = |(stat_q & mask_q);
endmodule

// File: rtl/mbc_top.sv
module mbc_top
    import mbc_pkg::*;
#(
    parameter int NEV         = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ale_i,
    input  logic             cs_n_i,
    input  logic             rd_n_i,
    input  logic             wr_n_i,
    input  logic [BUS_W-1:0] ad_i,
    output logic [BUS_W-1:0] ad_o,
    output logic             ad_oe_o,
    input  logic [NEV-1:0]   evt_i,
    output logic             irq_n_o,
    output logic             par_chk_en_o,
    output logic [1:0]       mult_sel_o,
    output logic [2:0]       line_rate_o
);
    logic [3:0]       strb_raw, strb_s;
    logic [BUS_W-1:0] ad_s;
    logic             ale_fall, rd_start, rd_active, wr_commit, irq;
    ctrl_t            ctrl_q;
    logic [BUS_W-1:0] addr_q;
    logic [NEV-1:0]   stat_q, ev_set;
    logic [BUS_W-1:0] rd_data;

    assign strb_raw = {ale_i, cs_n_i, rd_n_i, wr_n_i};

    mbc_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0111)) u_strb_sync (
        .clk(clk), .rst_n(rst_n), .d(strb_raw), .q(strb_s)
    );

    mbc_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_ad_sync (
        .clk(clk), .rst_n(rst_n), .d(ad_i), .q(ad_s)
    );

    mbc_bus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ale_s     (strb_s[3]),
        .cs_s      (~strb_s[2]),
        .rd_s      (~strb_s[1]),
        .wr_s      (~strb_s[0]),
        .ale_fall  (ale_fall),
        .rd_start  (rd_start),
        .rd_active (rd_active),
        .wr_commit (wr_commit)
    );

    mbc_regs #(.NEV(NEV)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ale_fall  (ale_fall),
        .ad_s      (ad_s),
        .rd_start  (rd_start),
        .rd_active (rd_active),
        .wr_commit (wr_commit),
        .evt       (evt_i),
        .ctrl_q    (ctrl_q),
        .addr_q    (addr_q),
        .stat_q    (stat_q),
        .ev_set    (ev_set),
        .rd_data   (rd_data),
        .irq       (irq)
    );

    // Pad driver is enabled straight from the pins so it never lags the strobes.
    assign ad_oe_o      = ~rd_n_i & ~cs_n_i;
    assign ad_o         = rd_data;
    assign irq_n_o      = ~irq;
    assign par_chk_en_o = ctrl_q.par_en;
    assign mult_sel_o   = ctrl_q.mult;

    always_comb begin
        unique case (ctrl_q.mult)
            2'b01:   line_rate_o = 3'b010;
            2'b10:   line_rate_o = 3'b100;
            default: line_rate_o = 3'b001;
        endcase
    end
endmodule

// File: rtl/mbc_checker.sv
module mbc_checker #(
    parameter int NEV = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           irq_n,
    input logic           rd_start,
    input logic           wr_commit,
    input logic [7:0]     addr,
    input logic [NEV-1:0] status,
    input logic [NEV-1:0] ev_set,
    input logic [2:0]     ctrl,
    input logic [2:0]     line_rate
);
    p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_commit |=> $stable(ctrl));

    p_rate_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(line_rate) == 1);

    p_stat_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_start |=> ((status & $past(status)) == $past(status)));

    p_ev_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_set) |=> ((status & $past(ev_set)) == $past(ev_set)));

    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !rd_start && !wr_commit) |=> !irq_n);

    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && addr == 8'h02) |=> ((status & $past(status) & ~$past(ev_set)) == '0));
endmodule

bind mbc_top mbc_checker #(.NEV(NEV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_n     (irq_n_o),
    .rd_start  (rd_start),
    .wr_commit (wr_commit),
    .addr      (addr_q),
    .status    (stat_q),
    .ev_set    (ev_set),
    .ctrl      (ctrl_q),
    .line_rate (line_rate_o)
);

// File: tb/test_mbc_top.sv
module test_mbc_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ale = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] ad_drv = 8'h00;
    logic [7:0] ad_o;
    logic       ad_oe, irq_n, par_en;
    logic [1:0] mult;
    logic [2:0] rate;
    logic [3:0] ev = 4'h0;

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state
    logic [2:0] m_ctrl = 3'b000;
    logic [3:0] m_mask = 4'h0;
    logic [3:0] m_stat = 4'h0;
    logic       m_clr = 1'b0;
    logic       m_wr = 1'b0;
    logic [7:0] m_wa = 8'h00, m_wd = 8'h00;
    logic       cmp_on = 1'b0;

    always #5 clk = ~clk;

    mbc_top i_mbc_top (
        .clk(clk), .rst_n(rst_n), .ale_i(ale), .cs_n_i(cs_n), .rd_n_i(rd_n),
        .wr_n_i(wr_n), .ad_i(ad_drv), .ad_o(ad_o), .ad_oe_o(ad_oe), .evt_i(ev),
        .irq_n_o(irq_n), .par_chk_en_o(par_en), .mult_sel_o(mult), .line_rate_o(rate)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_rate(input logic [1:0] m);
        case (m)
            2'b01:   return 3'b010;
            2'b10:   return 3'b100;
            default: return 3'b001;
        endcase
    endfunction

    // Model update on each edge
    always @(posedge clk) begin
        if (rst_n) begin
            m_stat <= (m_clr ? 4'h0 : m_stat) | (ev & {3'b111, m_ctrl[0]});
            if (m_wr) begin
                if (m_wa == 8'h00) m_ctrl <= m_wd[2:0];
                else if (m_wa == 8'h01) m_mask <= m_wd[3:0];
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R8 irq_n", irq_n, !(|(m_stat & m_mask)));
            chk("R6 line_rate", rate, exp_rate(m_ctrl[2:1]));
            chk("R3 par_chk_en", par_en, m_ctrl[0]);
            chk("R3 mult_sel", mult, m_ctrl[2:1]);
        end
    end

    task automatic latch_addr(input logic [7:0] a);
        ad_drv = a;
        ale = 1'b1;
        repeat (3) @(negedge clk);
        ale = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d,
                            input bit end_by_cs, input bit hold_cs);
        latch_addr(a);
        ad_drv = d;
        cs_n = 1'b0;
        wr_n = 1'b0;
        repeat (4) @(negedge clk);
        if (end_by_cs) cs_n = 1'b1;
        else           wr_n = 1'b1;
        repeat (2) @(negedge clk);
        m_wa = a; m_wd = d; m_wr = 1'b1;
        @(negedge clk);
        m_wr = 1'b0;
        wr_n = 1'b1;
        if (!hold_cs) cs_n = 1'b1;
        ad_drv = 8'hA5;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_read(input string tag, input logic [7:0] a, input bit relatch,
                           input bit hold_cs, input logic [3:0] ev_at_start);
        logic [7:0] exp;
        if (relatch) latch_addr(a);
        ad_drv = 8'h5A;
        cs_n = 1'b0;
        rd_n = 1'b0;
        repeat (2) @(negedge clk);
        case (a)
            8'h00:   exp = {5'b0, m_ctrl};
            8'h01:   exp = {4'b0, m_mask};
            8'h02:   exp = {4'b0, m_stat};
            default: exp = 8'h00;
        endcase
        if (a == 8'h02) m_clr = 1'b1;
        ev = ev_at_start;
        @(negedge clk);
        m_clr = 1'b0;
        ev = 4'h0;
        @(negedge clk);
        chk({"R4 oe during read ", tag}, ad_oe, 1'b1);
        chk(tag, ad_o, exp);
        rd_n = 1'b1;
        #1;
        chk("R4 oe off after read", ad_oe, 1'b0);
        if (!hold_cs) cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_ev(input logic [3:0] e);
        ev = e;
        @(negedge clk);
        ev = 4'h0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 irq_n in reset", irq_n, 1'b1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        cmp_on = 1'b1;
        // R1: reset state
        chk("R1 ad_oe idle", ad_oe, 1'b0);
        chk("R1 line_rate", rate, 3'b001);
        do_read("R1 ctrl reset", 8'h00, 1, 0, 4'h0);
        do_read("R1 mask reset", 8'h01, 1, 0, 4'h0);
        do_read("R1 stat reset", 8'h02, 1, 0, 4'h0);

        // R6: multiplier decode, R3: write ended by WR
        do_write(8'h00, 8'h04, 0, 0);
        do_read("R6 ctrl 4x readback", 8'h00, 1, 0, 4'h0);
        do_write(8'h00, 8'h06, 0, 0);
        chk("R6 reserved 11 gives 1x", rate, 3'b001);
        do_write(8'h00, 8'h02, 0, 0);
        chk("R6 2x", rate, 3'b010);

        // R3: write ended by CS trailing edge
        do_write(8'h01, 8'h05, 1, 0);
        do_read("R3 mask via cs edge", 8'h01, 1, 0, 4'h0);

        // R2: address persists without new ALE
        do_read("R2 mask reread same addr", 8'h01, 0, 0, 4'h0);

        // R4: oe stays off with cs high
        rd_n = 1'b0;
        #1;
        chk("R4 oe off when cs high", ad_oe, 1'b0);
        rd_n = 1'b1;
        repeat (3) @(negedge clk);

        // R5: cs held low through several accesses
        cs_n = 1'b0;
        do_write(8'h01, 8'h00, 0, 1);
        do_write(8'h00, 8'h00, 0, 1);
        do_read("R5 ctrl with cs held", 8'h00, 1, 1, 4'h0);
        do_read("R5 mask with cs held", 8'h01, 1, 1, 4'h0);
        cs_n = 1'b1;
        @(negedge clk);

        // R7: parity event gated by enable; R8: masked event still recorded
        pulse_ev(4'b0001);
        do_read("R7 parity event ignored when disabled", 8'h02, 1, 0, 4'h0);
        pulse_ev(4'b0100);
        chk("R8 masked event no irq", irq_n, 1'b1);
        do_read("R8 masked event recorded", 8'h02, 1, 0, 4'h0);
        do_read("R9 status cleared after read", 8'h02, 0, 0, 4'h0);
        do_write(8'h00, 8'h01, 0, 0);
        pulse_ev(4'b0001);
        do_read("R7 parity event when enabled", 8'h02, 1, 0, 4'h0);

        // R8/R9: unmasked event drives irq until read
        do_write(8'h01, 8'h0F, 0, 0);
        pulse_ev(4'b0010);
        repeat (5) @(negedge clk);
        chk("R8 irq held low", irq_n, 1'b0);
        do_read("R9 status read", 8'h02, 1, 0, 4'h0);
        chk("R9 irq released after read", irq_n, 1'b1);

        // R9: event in the read-start cycle is kept
        do_read("R9 same-cycle event excluded", 8'h02, 1, 0, 4'b1000);
        chk("R9 irq from kept event", irq_n, 1'b0);
        do_read("R9 kept event on next read", 8'h02, 0, 0, 4'h0);
        chk("R9 irq clear", irq_n, 1'b1);

        // R10: unmapped and status writes ignored
        do_write(8'h07, 8'hFF, 0, 0);
        do_read("R10 unmapped reads zero", 8'h07, 1, 0, 4'h0);
        do_write(8'h02, 8'hFF, 0, 0);
        do_read("R10 status write ignored", 8'h02, 1, 0, 4'h0);
        do_read("R10 ctrl unchanged", 8'h00, 1, 0, 4'h0);
        do_read("R10 mask unchanged", 8'h01, 1, 0, 4'h0);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule